// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the raster timing for a video system where one dot equals four master clocks. A master-clock position counter runs across each scanline. From it the block derives a dot enable, a horizontal dot counter and a vertical line counter. It also decodes an active-picture flag, a vertical blanking flag and a mid-line window in which the CPU must pause so that memory refresh can take place.

The frame length depends on a region select: the last line is 261 for 60 Hz and 311 for 50 Hz. An overscan bit moves the last visible line from 224 to 239, and blanking starts on the line after it. With interlace enabled, every even field carries one extra line. A field flag toggles at each frame wrap. Region, overscan and interlace are taken in only when the frame wraps, so a frame keeps its length while it runs. Force-blank acts at once and only masks the active-picture flag.

Rendering logic downstream uses `dotEn` to clock its pixel pipeline. It uses `hDot` and `vLine` to address its fetches, and it uses `vBlank` and `cpuPause` to schedule memory traffic.

Top module: `raster_timer`

## Requirements
- R1: After reset, `hDot` and `vLine` are 0, `oddField` is 0, and `vBlank`, `cpuPause` and `picActive` are low. The first frame uses the 60 Hz length with overscan and interlace off.
- R2: A line lasts LINE_CLKS master clocks (default 1364). The position counts 0 to LINE_CLKS-1 and then wraps. `dotEn` is high on the clock where position mod DOT_DIV equals DOT_DIV-1 (default DOT_DIV 4). `hDot` equals position / DOT_DIV, so it runs from 0 to 340 by default.
- R3: `cpuPause` is high exactly while the position lies in [PAUSE_AT, PAUSE_AT+PAUSE_CLKS), which is 536 to 575 by default (40 clocks), on every line.
- R4: `picActive` is high exactly when all of the following hold: `vLine` is in 1..visLast, the position is in [PIC_FIRST, PIC_LIMIT) (default 88 to 1111), and `forceBlank` is low. `forceBlank` takes effect in the same cycle.
- R5: visLast is 224 when the latched overscan bit is 0 and 239 when it is 1. `vBlank` is high on lines visLast+1 through the last line of the frame, and low on line 0.
- R6: The last line of a frame is 261 when the latched `regionPal` is 0 and 311 when it is 1. After the last line, `vLine` returns to 0.
- R7: When the latched interlace bit is 1 and `oddField` is 0, the frame carries one extra line: its last line is 262 or 312.
- R8: `oddField` inverts at each wrap of `vLine` to 0 and holds at all other times.
- R9: `regionPal`, `overscan` and `interlace` are sampled only on the final clock of a frame. Changing them mid-frame does not alter the length of the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regionPal | input | 1 | 1 selects the 50 Hz frame length, 0 the 60 Hz length |
| overscan | input | 1 | 1 extends the visible lines to 239 |
| interlace | input | 1 | 1 adds an extra line to even fields |
| forceBlank | input | 1 | Masks the active-picture flag |
| dotEn | output | 1 | One-clock strobe at the end of each dot |
| hDot | output | $clog2(LINE_CLKS/DOT_DIV) | Dot index within the line |
| vLine | output | $clog2(LAST_LINE_50+2) | Line index within the frame |
| picActive | output | 1 | Inside the displayed picture |
| vBlank | output | 1 | Vertical blanking interval |
| cpuPause | output | 1 | Refresh window during which the CPU is held |
| oddField | output | 1 | Field flag, 0 on even fields |

## Verification
The bench builds the block with a shrunken raster: 40 clocks per line, pause at positions 20 to 25, picture at positions 8 to 31, visible lines ending at 6 or 9, and last lines of 12 or 16. These values keep a frame to a few hundred clocks. Many frames therefore fit in a run, and every region, overscan and interlace combination is reached, including the field alternation and the mid-frame configuration changes. The dot divider stays at 4, so the power-of-two dot-enable path is the one exercised.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Strobes passed from control to datapath each master clock
  typedef struct packed {
    logic lineWrap;   // last master clock of the line
    logic frameWrap;  // last master clock of the frame
  } stepStrobes_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int LINE_CLKS    = 1364,
  parameter int VIS_LAST_STD = 224,
  parameter int VIS_LAST_OVR = 239,
  parameter int LAST_LINE_60 = 261,
  parameter int LAST_LINE_50 = 311,
  localparam int POS_W = $clog2(LINE_CLKS),
  localparam int V_W   = $clog2(LAST_LINE_50 + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regionPal,
  input  logic             overscan,
  input  logic             interlace,
  input  logic [POS_W-1:0] masterPos,
  input  logic [V_W-1:0]   vLine,
  output stepStrobes_t     step,
  output logic [V_W-1:0]   visLast,
  output logic             oddField
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_CLKS - 1);
  localparam logic [V_W-1:0]   L60      = V_W'(LAST_LINE_60);
  localparam logic [V_W-1:0]   L50      = V_W'(LAST_LINE_50);
  localparam logic [V_W-1:0]   VSTD     = V_W'(VIS_LAST_STD);
  localparam logic [V_W-1:0]   VOVR     = V_W'(VIS_LAST_OVR);

  logic cfgPal, cfgOvr, cfgIl;
  logic extraLine;
  logic [V_W-1:0] lastLine;

  assign extraLine = cfgIl & ~oddField;
  assign lastLine  = (cfgPal ? L50 : L60) + {{(V_W-1){1'b0}}, extraLine};
  assign visLast   = cfgOvr ? VOVR : VSTD;

  assign step.lineWrap  = (masterPos == POS_LAST);
  assign step.frameWrap = step.lineWrap && (vLine == lastLine);

  // Configuration and field flag only move at the frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPal   <= 1'b0;
      cfgOvr   <= 1'b0;
      cfgIl    <= 1'b0;
      oddField <= 1'b0;
    end else if (step.frameWrap) begin
      cfgPal   <= regionPal;
      cfgOvr   <= overscan;
      cfgIl    <= interlace;
      oddField <= ~oddField;
    end
  end
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int LINE_CLKS    = 1364,
  parameter int DOT_DIV      = 4,
  parameter int PIC_FIRST    = 88,
  parameter int PIC_LIMIT    = 1112,
  parameter int PAUSE_AT     = 536,
  parameter int PAUSE_CLKS   = 40,
  parameter int LAST_LINE_50 = 311,
  localparam int POS_W = $clog2(LINE_CLKS),
  localparam int DOT_W = $clog2(LINE_CLKS / DOT_DIV),
  localparam int V_W   = $clog2(LAST_LINE_50 + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepStrobes_t     step,
  input  logic [V_W-1:0]   visLast,
  input  logic             forceBlank,
  output logic [POS_W-1:0] masterPos,
  output logic             dotEn,
  output logic [DOT_W-1:0] hDot,
  output logic [V_W-1:0]   vLine,
  output logic             picActive,
  output logic             vBlank,
  output logic             cpuPause
);
  localparam logic [POS_W:0] PIC_A   = (POS_W+1)'(PIC_FIRST);
  localparam logic [POS_W:0] PIC_B   = (POS_W+1)'(PIC_LIMIT);
  localparam logic [POS_W:0] PAUSE_A = (POS_W+1)'(PAUSE_AT);
  localparam logic [POS_W:0] PAUSE_B = (POS_W+1)'(PAUSE_AT + PAUSE_CLKS);
  localparam bit DIV_POW2 = ((DOT_DIV & (DOT_DIV - 1)) == 0);
  localparam int SUB_W = (DOT_DIV > 1) ? $clog2(DOT_DIV) : 1;

  logic [POS_W:0] posWide;
  assign posWide = {1'b0, masterPos};

  // Master-clock position within the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              masterPos <= '0;
    else if (step.lineWrap) masterPos <= '0;
    else                    masterPos <= masterPos + 1'b1;
  end

  // Dot enable: low bits of the position for power-of-two dividers,
  // a separate phase counter otherwise
  generate
    if (DIV_POW2) begin : g_dotBits
      assign dotEn = &masterPos[SUB_W-1:0];
    end else begin : g_dotCnt
      localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(DOT_DIV - 1);
      logic [SUB_W-1:0] subPhase;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              subPhase <= '0;
        else if (step.lineWrap || subPhase == SUB_LAST) subPhase <= '0;
        else                                    subPhase <= subPhase + 1'b1;
      end
      assign dotEn = (subPhase == SUB_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hDot <= '0;
    else if (step.lineWrap) hDot <= '0;
    else if (dotEn)         hDot <= hDot + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vLine <= '0;
    else if (step.frameWrap) vLine <= '0;
    else if (step.lineWrap)  vLine <= vLine + 1'b1;
  end

  // Window decodes
  logic lineVisible, spanInside;
  assign lineVisible = (vLine != '0) && (vLine <= visLast);
  assign spanInside  = (posWide >= PIC_A) && (posWide < PIC_B);
  assign picActive   = lineVisible && spanInside && !forceBlank;
  assign vBlank      = (vLine > visLast);
  assign cpuPause    = (posWide >= PAUSE_A) && (posWide < PAUSE_B);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int LINE_CLKS    = 1364,
  parameter int DOT_DIV      = 4,
  parameter int PIC_FIRST    = 88,
  parameter int PIC_LIMIT    = 1112,
  parameter int PAUSE_AT     = 536,
  parameter int PAUSE_CLKS   = 40,
  parameter int VIS_LAST_STD = 224,
  parameter int VIS_LAST_OVR = 239,
  parameter int LAST_LINE_60 = 261,
  parameter int LAST_LINE_50 = 311,
  localparam int POS_W = $clog2(LINE_CLKS),
  localparam int DOT_W = $clog2(LINE_CLKS / DOT_DIV),
  localparam int V_W   = $clog2(LAST_LINE_50 + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regionPal,
  input  logic             overscan,
  input  logic             interlace,
  input  logic             forceBlank,
  output logic             dotEn,
  output logic [DOT_W-1:0] hDot,
  output logic [V_W-1:0]   vLine,
  output logic             picActive,
  output logic             vBlank,
  output logic             cpuPause,
  output logic             oddField
);
  stepStrobes_t     step;
  logic [V_W-1:0]   visLast;
  logic [POS_W-1:0] masterPos;

  raster_ctrl #(
    .LINE_CLKS(LINE_CLKS), .VIS_LAST_STD(VIS_LAST_STD), .VIS_LAST_OVR(VIS_LAST_OVR),
    .LAST_LINE_60(LAST_LINE_60), .LAST_LINE_50(LAST_LINE_50)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regionPal(regionPal), .overscan(overscan),
    .interlace(interlace), .masterPos(masterPos), .vLine(vLine),
    .step(step), .visLast(visLast), .oddField(oddField)
  );

  raster_dp #(
    .LINE_CLKS(LINE_CLKS), .DOT_DIV(DOT_DIV), .PIC_FIRST(PIC_FIRST),
    .PIC_LIMIT(PIC_LIMIT), .PAUSE_AT(PAUSE_AT), .PAUSE_CLKS(PAUSE_CLKS),
    .LAST_LINE_50(LAST_LINE_50)
  ) u_dp (
    .clk(clk), .rstN(rstN), .step(step), .visLast(visLast),
    .forceBlank(forceBlank), .masterPos(masterPos), .dotEn(dotEn),
    .hDot(hDot), .vLine(vLine), .picActive(picActive), .vBlank(vBlank),
    .cpuPause(cpuPause)
  );
endmodule

// File: rtl/raster_chk.sv
module raster_chk
  import raster_pkg::*;
#(
  parameter int LINE_CLKS    = 1364,
  parameter int DOT_DIV      = 4,
  parameter int PAUSE_AT     = 536,
  parameter int PAUSE_CLKS   = 40,
  parameter int LAST_LINE_50 = 311,
  localparam int POS_W = $clog2(LINE_CLKS),
  localparam int DOT_W = $clog2(LINE_CLKS / DOT_DIV),
  localparam int V_W   = $clog2(LAST_LINE_50 + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             forceBlank,
  input stepStrobes_t     step,
  input logic [POS_W-1:0] masterPos,
  input logic             dotEn,
  input logic [DOT_W-1:0] hDot,
  input logic [V_W-1:0]   vLine,
  input logic             picActive,
  input logic             vBlank,
  input logic             cpuPause,
  input logic             oddField
);
  localparam logic [POS_W-1:0] P_START = POS_W'(PAUSE_AT);
  localparam logic [POS_W-1:0] P_END   = POS_W'((PAUSE_AT + PAUSE_CLKS) % LINE_CLKS);

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    step.lineWrap |=> (masterPos == '0 && hDot == '0)); // R2
  AST_DOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dotEn && !step.lineWrap) |=> $stable(hDot)); // R2
  AST_PAUSE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuPause) |-> masterPos == P_START); // R3
  AST_PAUSE_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuPause) |-> masterPos == P_END); // R3
  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (!rstN)
    forceBlank |-> !picActive); // R4
  AST_ACTIVE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    picActive |-> (!vBlank && vLine != '0)); // R4
  AST_LINE0_UNBLANKED: assert property (@(posedge clk) disable iff (!rstN)
    (vLine == '0) |-> !vBlank); // R5
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !step.lineWrap |=> $stable(vLine)); // R6
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    step.frameWrap |=> (oddField != $past(oddField) && vLine == '0)); // R8
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !step.frameWrap |=> $stable(oddField)); // R8
endmodule

bind raster_timer raster_chk #(
  .LINE_CLKS(LINE_CLKS), .DOT_DIV(DOT_DIV), .PAUSE_AT(PAUSE_AT),
  .PAUSE_CLKS(PAUSE_CLKS), .LAST_LINE_50(LAST_LINE_50)
) u_chk (
  .clk(clk), .rstN(rstN), .forceBlank(forceBlank), .step(step),
  .masterPos(masterPos), .dotEn(dotEn), .hDot(hDot), .vLine(vLine),
  .picActive(picActive), .vBlank(vBlank), .cpuPause(cpuPause),
  .oddField(oddField)
);

// File: tb/raster_timer_tb.sv
`timescale 1ns/1ps
module raster_timer_tb;
  localparam int LC  = 40;
  localparam int DD  = 4;
  localparam int PF  = 8;
  localparam int PL  = 32;
  localparam int PA  = 20;
  localparam int PC  = 6;
  localparam int VS  = 6;
  localparam int VO  = 9;
  localparam int L60 = 12;
  localparam int L50 = 16;
  localparam int DOT_W = $clog2(LC / DD);
  localparam int V_W   = $clog2(L50 + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regionPal = 1'b0, overscan = 1'b0, interlace = 1'b0, forceBlank = 1'b0;
  logic dotEn, picActive, vBlank, cpuPause, oddField;
  logic [DOT_W-1:0] hDot;
  logic [V_W-1:0] vLine;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit monOn = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  raster_timer #(
    .LINE_CLKS(LC), .DOT_DIV(DD), .PIC_FIRST(PF), .PIC_LIMIT(PL),
    .PAUSE_AT(PA), .PAUSE_CLKS(PC), .VIS_LAST_STD(VS), .VIS_LAST_OVR(VO),
    .LAST_LINE_60(L60), .LAST_LINE_50(L50)
  ) u_dut (.*);

  // Reference raster state from the requirements
  int mPos = 0, mLine = 0;
  bit mOdd = 0, cPal = 0, cOvr = 0, cIl = 0;

  function automatic int lastOf(bit pal, bit il, bit odd);
    return (pal ? L50 : L60) + ((il && !odd) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos = 0; mLine = 0; mOdd = 0; cPal = 0; cOvr = 0; cIl = 0;
    end else if (mPos == LC - 1) begin
      mPos = 0;
      if (mLine == lastOf(cPal, cIl, mOdd)) begin
        mLine = 0; mOdd = !mOdd;
        cPal = regionPal; cOvr = overscan; cIl = interlace;
      end else mLine = mLine + 1;
    end else mPos = mPos + 1;
  end

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d (line %0d pos %0d)", tag, got, exp, mLine, mPos);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      int vl;
      vl = cOvr ? VO : VS;
      check("R2 hDot", int'(hDot), mPos / DD);
      check("R2 dotEn", int'(dotEn), int'(mPos % DD == DD - 1));
      check("R3 cpuPause", int'(cpuPause), int'(mPos >= PA && mPos < PA + PC));
      check("R4 picActive", int'(picActive),
            int'(mLine >= 1 && mLine <= vl && mPos >= PF && mPos < PL && !forceBlank));
      check("R5 vBlank", int'(vBlank), int'(mLine > vl));
      check("R6 vLine", int'(vLine), mLine);
      check("R8 oddField", int'(oddField), int'(mOdd));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Run to the next wrap to line 0 and return the highest line seen
  task automatic waitFrame(output int maxLine);
    int prev;
    maxLine = int'(vLine);
    prev = int'(vLine);
    forever begin
      @(negedge clk);
      if (int'(vLine) > maxLine) maxLine = int'(vLine);
      if (vLine == '0 && prev != 0) break;
      prev = int'(vLine);
    end
  endtask

  task automatic waitLines(int n);
    repeat (n * LC) @(negedge clk);
  endtask

  initial begin
    int mx;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hDot", int'(hDot), 0);
    check("R1 vLine", int'(vLine), 0);
    check("R1 oddField", int'(oddField), 0);
    check("R1 vBlank", int'(vBlank), 0);
    check("R1 cpuPause", int'(cpuPause), 0);
    check("R1 picActive", int'(picActive), 0);
    rstN = 1'b1;
    monOn = 1'b1;

    // R9: change config during frame 0; frame 0 keeps default length
    waitLines(3);
    regionPal = 1'b1; interlace = 1'b1;
    waitFrame(mx);  check("R9 frame0 last", mx, L60);
    waitFrame(mx);  check("R6 odd pal last", mx, L50);
    waitFrame(mx);  check("R7 even interlace last", mx, L50 + 1);
    // R9: drop region mid-frame of odd field
    waitLines(4);
    regionPal = 1'b0;
    waitFrame(mx);  check("R9 midframe hold", mx, L50);
    waitFrame(mx);  check("R7 even interlace 60", mx, L60 + 1);
    interlace = 1'b0; overscan = 1'b1;
    waitFrame(mx);  check("R6 60 last", mx, L60);
    forceBlank = 1'b1;
    waitFrame(mx);  check("R5 overscan frame", mx, L60);

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      #1;
      forceBlank = ($urandom % 4) == 0;
      if (($urandom % 300) == 0) regionPal = ~regionPal;
      if (($urandom % 300) == 0) overscan  = ~overscan;
      if (($urandom % 300) == 0) interlace = ~interlace;
    end
    monOn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule